// File: doc/BRIEF.md
# Iterative Subtract-and-Swap GCD Engine

This block computes the greatest common divisor of two unsigned operands over several clock cycles. It never divides. On each step it either exchanges the two working values or subtracts the smaller from the larger, and it finishes when the second working value reaches zero. The unit handles one job at a time. While it waits for work it raises an idle flag. A producer offers an operand pair with a valid strobe, and the pair is captured when the strobe and the idle flag are both high.

When the answer is known, the unit raises a ready flag and holds the answer steady until the consumer pulses a taken signal. It then returns to waiting for work. Internally, a datapath holds the two working registers, each with its own input select and write enable, along with a less-than comparator, a zero detector and a subtractor. A three-state controller drives those selects and enables from the two comparison flags.

Top module: `gcd_iter_unit`

## Requirements
- R1: The operand and result width is the parameter `W`, which defaults to 16 bits.
- R2: Reset is synchronous and active low. After any clock edge taken with `rst_n` low, `acc_idle` is 1 and `res_valid` is 0, even if a computation was in progress.
- R3: A pair on `opnd_x`/`opnd_y` is captured at a clock edge where `acc_idle` and `req_valid` are both 1. After that edge `acc_idle` is 0 and stays 0 until the result has been taken.
- R4: `req_valid` and the operand inputs have no effect while `acc_idle` is 0. Operands offered during a busy or holding period do not change the result that is pending.
- R5: When the first working value is less than the second, one compute cycle exchanges the two values.
- R6: Otherwise, when the second working value is nonzero, one compute cycle replaces the first value with the difference (first minus second) and leaves the second unchanged.
- R7: When neither R5 nor R6 applies, the next edge raises `res_valid` and `res_data` carries the first working value. For any pair, the number of edges from capture to `res_valid` equals the number of steps taken under R5 and R6, plus one.
- R8: While `res_valid` is 1 and `res_taken` is 0, `res_data` and `res_valid` hold their values. `acc_idle` and `res_valid` are never both 1.
- R9: A clock edge with `res_valid` and `res_taken` both 1 returns the unit to idle, so `acc_idle` is 1 and `res_valid` is 0 after that edge.
- R10: If both operands are zero the result is 0. If exactly one operand is zero the result is the other operand.
- R11: For every pair, including equal operands and operands at the maximum value 2^W-1, the result equals the greatest common divisor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| opnd_x | input | W | First operand |
| opnd_y | input | W | Second operand |
| req_valid | input | 1 | Operand pair offered |
| acc_idle | output | 1 | Unit is waiting for a new pair |
| res_data | output | W | Greatest common divisor |
| res_valid | output | 1 | Result is present and held |
| res_taken | input | 1 | Consumer accepts the result |

## Verification
Two events can meet in the same cycle: the consumer pulsing `res_taken`, and a producer that has kept `req_valid` high with fresh operands while the unit was still working or holding a result. The bench sets this up by raising the strobe early and changing the operands on every cycle while `acc_idle` is low. It then delays `res_taken` by a random number of cycles. Checks confirm that the pending result was not disturbed, that idle returns on the edge after the take, and that the next pair is captured only on the following edge. A scoreboard of expected values and step counts judges each result.

// File: rtl/gcd_pkg.sv
// Package: shared types for the GCD engine.
// Assumes: nothing beyond IEEE 1800-2017 enums.
package gcd_pkg;

    // Controller phases
    typedef enum logic [1:0] {
        PH_WAIT_IN = 2'd0,
        PH_RUN     = 2'd1,
        PH_HOLD    = 2'd2
    } phase_e;

    // Source select for the first working register
    typedef enum logic [1:0] {
        XSRC_LOAD = 2'd0,
        XSRC_PEER = 2'd1,
        XSRC_DIFF = 2'd2
    } xsrc_e;

    // Source select for the second working register
    typedef enum logic {
        YSRC_LOAD = 1'b0,
        YSRC_PEER = 1'b1
    } ysrc_e;

endpackage

// File: rtl/gcd_datapath.sv
// Module: gcd_datapath
// Holds the two working values. Each register has its own source select
// and write enable. The module reports x<y and y==0 to the controller.
// Assumes: the controller asserts at most one legal select per register.
module gcd_datapath
    import gcd_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] load_x,
    input  logic [W-1:0] load_y,
    input  xsrc_e        x_src,
    input  logic         x_we,
    input  ysrc_e        y_src,
    input  logic         y_we,
    output logic         x_lt_y,
    output logic         y_is_zero,
    output logic [W-1:0] x_val,
    output logic [W-1:0] y_val
);

    logic [W-1:0] x_q, y_q;
    logic [W-1:0] x_next, y_next;
    logic [W-1:0] diff;

    // Subtractor: difference of the working values
    assign diff = x_q - y_q;

    // Source mux for the first register
    always_comb begin
        unique case (x_src)
            XSRC_PEER: x_next = y_q;
            XSRC_DIFF: x_next = diff;
            default:   x_next = load_x;
        endcase
    end

    // Source mux for the second register
    always_comb begin
        y_next = (y_src == YSRC_PEER) ? x_q : load_y;
    end

    // Working registers with enables
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            x_q <= '0;
            y_q <= '0;
        end else begin
            if (x_we) x_q <= x_next;
            if (y_we) y_q <= y_next;
        end
    end

    // Status flags toward the controller
    assign x_lt_y    = (x_q < y_q);
    assign y_is_zero = (y_q == '0);
    assign x_val     = x_q;
    assign y_val     = y_q;

endmodule

// File: rtl/gcd_ctrl.sv
// Module: gcd_ctrl
// Three-phase controller that sequences the datapath. It waits for a pair,
// steps the loop, then holds the result until it is taken.
// Assumes: status flags describe the registered working values.
module gcd_ctrl
    import gcd_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   req_valid,
    input  logic   res_taken,
    input  logic   x_lt_y,
    input  logic   y_is_zero,
    output xsrc_e  x_src,
    output logic   x_we,
    output ysrc_e  y_src,
    output logic   y_we,
    output logic   acc_idle,
    output logic   res_valid,
    output logic   running
);

    phase_e ph_q, ph_d;

    // Phase register
    always_ff @(posedge clk) begin
        if (!rst_n) ph_q <= PH_WAIT_IN;
        else        ph_q <= ph_d;
    end

    // Next phase and datapath controls
    always_comb begin
        ph_d  = ph_q;
        x_src = XSRC_LOAD;
        y_src = YSRC_LOAD;
        x_we  = 1'b0;
        y_we  = 1'b0;
        unique case (ph_q)
            PH_WAIT_IN: begin
                if (req_valid) begin
                    x_we = 1'b1;
                    y_we = 1'b1;
                    ph_d = PH_RUN;
                end
            end
            PH_RUN: begin
                if (x_lt_y) begin
                    x_src = XSRC_PEER;
                    y_src = YSRC_PEER;
                    x_we  = 1'b1;
                    y_we  = 1'b1;
                end else if (!y_is_zero) begin
                    x_src = XSRC_DIFF;
                    x_we  = 1'b1;
                end else begin
                    ph_d = PH_HOLD;
                end
            end
            PH_HOLD: begin
                if (res_taken) ph_d = PH_WAIT_IN;
            end
            default: ph_d = PH_WAIT_IN;
        endcase
    end

    // Handshake flags decoded from the phase
    assign acc_idle  = (ph_q == PH_WAIT_IN);
    assign res_valid = (ph_q == PH_HOLD);
    assign running   = (ph_q == PH_RUN);

endmodule

// File: rtl/gcd_iter_unit.sv
// Module: gcd_iter_unit (top)
// Wires the controller to the datapath and exposes the request and
// response handshakes. It handles one job at a time.
// Assumes: synchronous active-low reset and a single clock.
module gcd_iter_unit
    import gcd_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] opnd_x,
    input  logic [W-1:0] opnd_y,
    input  logic         req_valid,
    output logic         acc_idle,
    output logic [W-1:0] res_data,
    output logic         res_valid,
    input  logic         res_taken
);

    xsrc_e        x_src;
    ysrc_e        y_src;
    logic         x_we, y_we;
    logic         x_lt_y, y_is_zero;
    logic         running;
    logic [W-1:0] x_val, y_val;

    gcd_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .res_taken (res_taken),
        .x_lt_y    (x_lt_y),
        .y_is_zero (y_is_zero),
        .x_src     (x_src),
        .x_we      (x_we),
        .y_src     (y_src),
        .y_we      (y_we),
        .acc_idle  (acc_idle),
        .res_valid (res_valid),
        .running   (running)
    );

    gcd_datapath #(.W(W)) u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_x    (opnd_x),
        .load_y    (opnd_y),
        .x_src     (x_src),
        .x_we      (x_we),
        .y_src     (y_src),
        .y_we      (y_we),
        .x_lt_y    (x_lt_y),
        .y_is_zero (y_is_zero),
        .x_val     (x_val),
        .y_val     (y_val)
    );

    // The result is the first working value
    assign res_data = x_val;

endmodule

// File: rtl/gcd_iter_unit_checker.sv
// Module: gcd_iter_unit_checker
// Protocol and step properties for gcd_iter_unit. It is attached by bind.
// Assumes: it observes the top-level ports and the internal status wires.
module gcd_iter_unit_checker #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         req_valid,
    input logic         acc_idle,
    input logic [W-1:0] res_data,
    input logic         res_valid,
    input logic         res_taken,
    input logic         running,
    input logic         x_lt_y,
    input logic         y_is_zero,
    input logic [W-1:0] x_val,
    input logic [W-1:0] y_val
);

    assert_reset_idle_R2: assert property (@(posedge clk)
        !rst_n |=> (acc_idle && !res_valid));

    assert_accept_leaves_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_idle && req_valid) |=> (!acc_idle && !res_valid));

    assert_swap_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (running && x_lt_y) |=> (x_val == $past(y_val) && y_val == $past(x_val)));

    assert_sub_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !x_lt_y && !y_is_zero) |=>
            (x_val == $past(x_val) - $past(y_val) && y_val == $past(y_val)));

    assert_finish_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !x_lt_y && y_is_zero) |=> (res_valid && res_data == $past(x_val)));

    assert_hold_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_taken) |=> (res_valid && $stable(res_data)));

    assert_flags_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_idle && res_valid));

    assert_take_returns_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_taken) |=> (acc_idle && !res_valid));

endmodule

bind gcd_iter_unit gcd_iter_unit_checker #(.W(W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .acc_idle  (acc_idle),
    .res_data  (res_data),
    .res_valid (res_valid),
    .res_taken (res_taken),
    .running   (running),
    .x_lt_y    (x_lt_y),
    .y_is_zero (y_is_zero),
    .x_val     (x_val),
    .y_val     (y_val)
);

// File: tb/gcd_iter_unit_bench.sv
// Scoreboard bench for gcd_iter_unit. The driver pushes expected items into
// a queue. The monitor pops one item per result and compares it.
module gcd_iter_unit_bench;

    localparam int W = 16;
    localparam logic [W-1:0] MAXV = {W{1'b1}};

    typedef struct {
        logic [W-1:0] a;
        logic [W-1:0] b;
        logic [W-1:0] g;
        int           steps;
        int           acc_cyc;
    } item_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] opnd_x = '0;
    logic [W-1:0] opnd_y = '0;
    logic         req_valid = 1'b0;
    logic         acc_idle;
    logic [W-1:0] res_data;
    logic         res_valid;
    logic         res_taken = 1'b0;

    int     n_cmp = 0;
    int     n_bad = 0;
    int     cyc = 0;
    int     n_sent = 0;
    int     n_done = 0;
    bit     finished = 1'b0;
    item_t  sb_q[$];

    always #4 clk = ~clk;   // 125 MHz

    always @(posedge clk) cyc <= cyc + 1;

    gcd_iter_unit #(.W(W)) u_gcd_iter_unit (
        .clk       (clk),
        .rst_n     (rst_n),
        .opnd_x    (opnd_x),
        .opnd_y    (opnd_y),
        .req_valid (req_valid),
        .acc_idle  (acc_idle),
        .res_data  (res_data),
        .res_valid (res_valid),
        .res_taken (res_taken)
    );

    // Count one comparison and report a mismatch
    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // Reference GCD by remainder (R11)
    function automatic logic [W-1:0] ref_gcd(input logic [W-1:0] a, input logic [W-1:0] b);
        logic [W-1:0] x = a, y = b, t;
        while (y != 0) begin
            t = x % y;
            x = y;
            y = t;
        end
        return x;
    endfunction

    // Expected edges to result: steps under R5/R6, plus the finishing one (R7)
    function automatic int ref_steps(input logic [W-1:0] a, input logic [W-1:0] b);
        logic [W-1:0] x = a, y = b, t;
        int n = 0;
        forever begin
            n++;
            if (x < y) begin t = x; x = y; y = t; end
            else if (y != 0) x = x - y;
            else break;
        end
        return n;
    endfunction

    // Driver: offer a pair, optionally with junk operands while busy (R4)
    task automatic send(input logic [W-1:0] a, input logic [W-1:0] b, input bit noise);
        item_t it;
        forever begin
            @(negedge clk);
            if (acc_idle) begin
                req_valid = 1'b1;
                opnd_x = a;
                opnd_y = b;
                @(posedge clk);
                @(negedge clk);
                req_valid = 1'b0;
                opnd_x = $urandom();
                opnd_y = $urandom();
                check(!acc_idle, "R3 idle after capture", acc_idle, 0);
                it.a = a; it.b = b; it.g = ref_gcd(a, b);
                it.steps = ref_steps(a, b);
                it.acc_cyc = cyc;
                sb_q.push_back(it);
                n_sent++;
                break;
            end else if (noise) begin
                req_valid = 1'b1;
                opnd_x = $urandom();
                opnd_y = $urandom();
            end else begin
                req_valid = 1'b0;
            end
        end
    endtask

    // Monitor: compare each result, hold for a random time, then take it
    task automatic monitor();
        item_t it;
        logic [W-1:0] held;
        int d;
        forever begin
            @(negedge clk);
            if (res_valid) begin
                if (sb_q.size() == 0) begin
                    check(1'b0, "R7 unexpected result", res_data, 0);
                end else begin
                    it = sb_q.pop_front();
                    check(res_data == it.g, "R11 gcd value", res_data, it.g);
                    if (it.a == 0 || it.b == 0)
                        check(res_data == (it.a | it.b), "R10 zero operand", res_data, it.a | it.b);
                    check((cyc - it.acc_cyc) == it.steps, "R5 R6 R7 step count",
                          cyc - it.acc_cyc, it.steps);
                    check(!acc_idle, "R8 idle low while holding", acc_idle, 0);
                    held = res_data;
                    d = $urandom_range(0, 4);
                    for (int k = 0; k < d; k++) begin
                        @(negedge clk);
                        check(res_valid && res_data == held, "R8 hold stable", res_data, held);
                    end
                    res_taken = 1'b1;
                    @(negedge clk);
                    res_taken = 1'b0;
                    check(acc_idle && !res_valid, "R9 idle after take", acc_idle, 1);
                end
                n_done++;
            end
        end
    endtask

    // Watchdog
    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            check(1'b0, "watchdog expired", cyc, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    // Main sequence
    initial begin
        logic [W-1:0] ra, rb;
        int sh;
        // R2: reset state
        repeat (2) @(posedge clk);
        @(negedge clk);
        check(acc_idle && !res_valid, "R2 reset state", {acc_idle, res_valid}, 2);
        rst_n = 1'b1;
        // R2: reset during a computation
        @(negedge clk);
        req_valid = 1'b1; opnd_x = 16'd200; opnd_y = 16'd3;
        @(negedge clk);
        req_valid = 1'b0;
        check(!acc_idle, "R3 capture before reset", acc_idle, 0);
        repeat (3) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(acc_idle && !res_valid, "R2 reset mid-run", {acc_idle, res_valid}, 2);
        rst_n = 1'b1;

        fork
            monitor();
        join_none

        // R1: default width, and directed corners (R10, R11)
        check($bits(res_data) == 16, "R1 width", $bits(res_data), 16);
        send(16'd0, 16'd0, 1'b0);
        send(16'd0, 16'd9, 1'b1);
        send(16'd9, 16'd0, 1'b1);
        send(16'd12, 16'd12, 1'b0);
        send(MAXV, MAXV, 1'b1);
        send(MAXV, 16'd0, 1'b0);
        send(16'd0, MAXV, 1'b1);
        send(MAXV, 16'd21845, 1'b1);
        send(16'd48, 16'd18, 1'b0);
        send(16'd18, 16'd48, 1'b1);
        send(16'd1, 16'd1, 1'b0);
        send(16'd1, 16'd7, 1'b1);
        // Random pairs with bounded quotients
        for (int i = 0; i < 40; i++) begin
            sh = $urandom_range(0, 8);
            ra = W'(($urandom() & 32'hFF) << sh);
            rb = W'(($urandom() & 32'hFF) << sh);
            send(ra, rb, i[0]);
        end
        wait (n_done == n_sent && sb_q.size() == 0);
        repeat (4) @(negedge clk);
        check(acc_idle && !res_valid, "R9 final idle", acc_idle, 1);
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule